// File: doc/BRIEF.md
# Dual-Strobe Presettable Up/Down Counter

This block is a 4-bit counter with no direction bit. Two count strobes steer it: a rising edge on the up strobe adds one, and a rising edge on the down strobe subtracts one. A build-time parameter selects the sequence. In decade mode the counter runs from 0 to 9. In binary mode it runs from 0 to 15. The largest value of the sequence is called the terminal value below.

A master clear input and an active-low parallel load input preset the counter. Two active-low terminal-count outputs copy the low phase of a strobe while the counter sits at an end of its sequence. Because of this, they can drive the strobes of a following stage directly to build multi-digit counters.

The design is fully synchronous to one system clock. Both strobes are treated as asynchronous. Each passes through a synchronizer and an edge detector before it can move the count. Clear and load are sampled on the system clock.

Top module: `updown_strobe_counter`

## Requirements
- R1: With the down strobe high, one rising edge on the up strobe adds exactly one to the count.
- R2: With the up strobe high, one rising edge on the down strobe subtracts exactly one from the count.
- R3: The terminal value is 9 when DECADE=1 and 15 when DECADE=0. Stepping up from the terminal value gives 0. Stepping down from 0 gives the terminal value.
- R4: In decade mode, a loaded value from 10 to 15 steps up to 0 and steps down to 9.
- R5: While `clr` is 1 at a clock edge, that edge sets the count to 0 and both terminal-count outputs to 1. This overrides `load_n` and both strobes.
- R6: With `clr` 0 and `load_n` 0 at a clock edge, the count takes `load_val` at that edge, whatever the strobes are doing.
- R7: With `clr` 0, `load_n` 1 and no strobe rising edge, the count keeps its value.
- R8: While the other strobe is low, a rising edge on one strobe leaves the count unchanged. Rising edges on both strobes in the same cycle also leave it unchanged.
- R9: If a strobe is held low through a load or a clear, its first rising edge after release is counted.
- R10: `up_tc_n` is 0 exactly while the count equals the terminal value and the synchronized up strobe is low. Otherwise it is 1.
- R11: `dn_tc_n` is 0 exactly while the count is 0 and the synchronized down strobe is low. Otherwise it is 1.
- R12: A strobe that rises just before clock edge k changes the count at edge k+2 and not before. This holds with SYNC_STAGES=2.
- R13: Two stages can be chained. The lower stage's `up_tc_n` and `dn_tc_n` drive the upper stage's `up_strb` and `dn_strb`, and the pair then counts correctly from 00 to 99 in both directions, wrapping at both ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| clr | input | 1 | Master clear, active high, synchronous |
| load_n | input | 1 | Parallel load, active low, synchronous |
| load_val | input | W | Value taken on load |
| up_strb | input | 1 | Count-up strobe, asynchronous |
| dn_strb | input | 1 | Count-down strobe, asynchronous |
| count | output | W | Current count |
| up_tc_n | output | 1 | Up terminal count, active low |
| dn_tc_n | output | 1 | Down terminal count, active low |

## Verification
A corrupted count register appears on `count` at the next clock edge. A wrong next-state decision for the end states shows up within one strobe pulse, as a missing wrap or a value beyond the terminal value. A fault in the synchronizer or the edge detector shows as a double step, a lost step, or a step one cycle early or late, and the latency checks catch it. A wrong terminal-count output often looks harmless on a single stage. In the two-stage chain it shows within one lower-digit rollover, because the upper digit then misses a step or takes an extra one.

// File: rtl/udc_pkg.sv
package udc_pkg;

  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_INC  = 2'd1,
    STEP_DEC  = 2'd2
  } step_e;

  localparam int DIR_UP = 0;
  localparam int DIR_DN = 1;
  localparam int NUM_DIRS = 2;

endpackage

// File: rtl/udc_strobe_sync.sv
module udc_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic clr,
  input  logic strb,
  output logic lvl,
  output logic lvl_next,
  output logic rise
);

  logic [STAGES-1:0] sr_q;
  logic              prev_q;

  // Reset to the idle (high) level so a strobe held low through clear
  // produces no edge until it really rises.
  always_ff @(posedge clk) begin
    if (clr) begin
      sr_q   <= '1;
      prev_q <= 1'b1;
    end else begin
      sr_q   <= {sr_q[STAGES-2:0], strb};
      prev_q <= sr_q[STAGES-1];
    end
  end

  assign lvl      = sr_q[STAGES-1];
  assign lvl_next = clr ? 1'b1 : sr_q[STAGES-2];
  assign rise     = lvl & ~prev_q;

endmodule

// File: rtl/udc_step_arb.sv
module udc_step_arb
  import udc_pkg::*;
(
  input  logic  up_lvl,
  input  logic  up_rise,
  input  logic  dn_lvl,
  input  logic  dn_rise,
  output step_e step
);

  always_comb begin
    step = STEP_NONE;
    if (up_rise && !dn_rise && dn_lvl) begin
      step = STEP_INC;
    end else if (dn_rise && !up_rise && up_lvl) begin
      step = STEP_DEC;
    end
  end

endmodule

// File: rtl/udc_count_core.sv
module udc_count_core
  import udc_pkg::*;
#(
  parameter int             W    = 4,
  parameter logic [W-1:0]   TERM = W'(9)
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         load_n,
  input  logic [W-1:0] load_val,
  input  step_e        step,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_d
);

  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONE  = W'(1);

  logic [W-1:0] inc_val;
  logic [W-1:0] dec_val;

  always_comb begin
    inc_val = (cnt_q >= TERM) ? ZERO : cnt_q + ONE;
    if (cnt_q == ZERO || cnt_q > TERM) begin
      dec_val = TERM;
    end else begin
      dec_val = cnt_q - ONE;
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = ZERO;
    end else if (!load_n) begin
      cnt_d = load_val;
    end else begin
      case (step)
        STEP_INC: cnt_d = inc_val;
        STEP_DEC: cnt_d = dec_val;
        default:  cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    cnt_q <= cnt_d;
  end

endmodule

// File: rtl/udc_term_detect.sv
module udc_term_detect #(
  parameter int           W     = 4,
  parameter logic [W-1:0] MATCH = '0
) (
  input  logic         clk,
  input  logic         clr,
  input  logic [W-1:0] cnt_d,
  input  logic         strb_lvl_next,
  output logic         tc_n
);

  // Registered from next-state values so the output lines up with the
  // registered count and the synchronized strobe of the same cycle.
  always_ff @(posedge clk) begin
    if (clr) begin
      tc_n <= 1'b1;
    end else begin
      tc_n <= !((cnt_d == MATCH) && !strb_lvl_next);
    end
  end

endmodule

// File: rtl/updown_strobe_counter.sv
module updown_strobe_counter
  import udc_pkg::*;
#(
  parameter int W           = 4,
  parameter bit DECADE      = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         load_n,
  input  logic [W-1:0] load_val,
  input  logic         up_strb,
  input  logic         dn_strb,
  output logic [W-1:0] count,
  output logic         up_tc_n,
  output logic         dn_tc_n
);

  localparam logic [W-1:0] TERM = DECADE ? W'(9) : {W{1'b1}};

  logic [NUM_DIRS-1:0] strb_in;
  logic [NUM_DIRS-1:0] lvl;
  logic [NUM_DIRS-1:0] lvl_nx;
  logic [NUM_DIRS-1:0] rise;
  logic [NUM_DIRS-1:0] tc_n;
  logic [W-1:0]        cnt_d;
  step_e               step;

  assign strb_in[DIR_UP] = up_strb;
  assign strb_in[DIR_DN] = dn_strb;

  for (genvar g = 0; g < NUM_DIRS; g++) begin : g_dir
    localparam logic [W-1:0] MATCH_G = (g == DIR_UP) ? TERM : '0;

    udc_strobe_sync #(
      .STAGES(SYNC_STAGES)
    ) sync_i (
      .clk      (clk),
      .clr      (clr),
      .strb     (strb_in[g]),
      .lvl      (lvl[g]),
      .lvl_next (lvl_nx[g]),
      .rise     (rise[g])
    );

    udc_term_detect #(
      .W     (W),
      .MATCH (MATCH_G)
    ) tc_i (
      .clk           (clk),
      .clr           (clr),
      .cnt_d         (cnt_d),
      .strb_lvl_next (lvl_nx[g]),
      .tc_n          (tc_n[g])
    );
  end

  udc_step_arb arb_i (
    .up_lvl  (lvl[DIR_UP]),
    .up_rise (rise[DIR_UP]),
    .dn_lvl  (lvl[DIR_DN]),
    .dn_rise (rise[DIR_DN]),
    .step    (step)
  );

  udc_count_core #(
    .W    (W),
    .TERM (TERM)
  ) core_i (
    .clk      (clk),
    .clr      (clr),
    .load_n   (load_n),
    .load_val (load_val),
    .step     (step),
    .cnt_q    (count),
    .cnt_d    (cnt_d)
  );

  assign up_tc_n = tc_n[DIR_UP];
  assign dn_tc_n = tc_n[DIR_DN];

endmodule

// File: rtl/updown_strobe_counter_chk.sv
module updown_strobe_counter_chk #(
  parameter int           W    = 4,
  parameter logic [W-1:0] TERM = W'(9)
) (
  input logic         clk,
  input logic         clr,
  input logic         load_n,
  input logic [W-1:0] load_val,
  input logic [W-1:0] count,
  input logic         up_tc_n,
  input logic         dn_tc_n
);

  function automatic logic [W-1:0] inc_of(input logic [W-1:0] v);
    return (v >= TERM) ? '0 : v + W'(1);
  endfunction

  function automatic logic [W-1:0] dec_of(input logic [W-1:0] v);
    return (v == '0 || v > TERM) ? TERM : v - W'(1);
  endfunction

  // R5: the edge after clear leaves a zero count and idle terminal outputs
  a_r5_clear_state: assert property (@(posedge clk) disable iff (clr)
    $past(clr) |-> (count == '0) && up_tc_n && dn_tc_n);

  // R6: a sampled load shows its data on the next cycle
  a_r6_load_value: assert property (@(posedge clk) disable iff (clr)
    (!$past(clr) && !$past(load_n)) |-> (count == $past(load_val)));

  // R1 R2 R3 R4: any change outside load and clear is one legal step
  a_r3_single_step: assert property (@(posedge clk) disable iff (clr)
    (!$past(clr) && $past(load_n) && (count != $past(count)))
      |-> (count == inc_of($past(count)) || count == dec_of($past(count))));

  // R4: stepping always lands inside the sequence
  a_r4_in_range: assert property (@(posedge clk) disable iff (clr)
    (!$past(clr) && $past(load_n) && (count != $past(count)))
      |-> (count <= TERM));

  // R10: up terminal output is low only at the terminal value
  a_r10_up_tc_end: assert property (@(posedge clk) disable iff (clr)
    (count != TERM) |-> up_tc_n);

  // R11: down terminal output is low only at zero
  a_r11_dn_tc_end: assert property (@(posedge clk) disable iff (clr)
    (count != '0) |-> dn_tc_n);

endmodule

bind updown_strobe_counter updown_strobe_counter_chk #(
  .W    (W),
  .TERM (TERM)
) chk_i (
  .clk      (clk),
  .clr      (clr),
  .load_n   (load_n),
  .load_val (load_val),
  .count    (count),
  .up_tc_n  (up_tc_n),
  .dn_tc_n  (dn_tc_n)
);

// File: tb/updown_strobe_counter_tb_top.sv
`timescale 1ns/1ps
module updown_strobe_counter_tb_top;

  logic       clk = 1'b0;
  logic       clr = 1'b1;
  logic       load_n = 1'b1;
  logic [3:0] load_val = 4'd0;
  logic       up_s = 1'b1;
  logic       dn_s = 1'b1;
  logic       c_up = 1'b1;
  logic       c_dn = 1'b1;

  logic [3:0] dec_cnt, bin_cnt, lo_cnt, hi_cnt;
  logic       dec_utc, dec_dtc, bin_utc, bin_dtc;
  logic       lo_utc, lo_dtc, hi_utc, hi_dtc;

  int n_chk = 0;
  int n_fail = 0;
  int exp_dec = 0;
  int exp_bin = 0;
  int exp_c = 0;

  always #10 clk = ~clk;

  updown_strobe_counter #(.W(4), .DECADE(1'b1)) dut_i (
    .clk(clk), .clr(clr), .load_n(load_n), .load_val(load_val),
    .up_strb(up_s), .dn_strb(dn_s),
    .count(dec_cnt), .up_tc_n(dec_utc), .dn_tc_n(dec_dtc));

  updown_strobe_counter #(.W(4), .DECADE(1'b0)) bin_i (
    .clk(clk), .clr(clr), .load_n(load_n), .load_val(load_val),
    .up_strb(up_s), .dn_strb(dn_s),
    .count(bin_cnt), .up_tc_n(bin_utc), .dn_tc_n(bin_dtc));

  updown_strobe_counter #(.W(4), .DECADE(1'b1)) lo_i (
    .clk(clk), .clr(clr), .load_n(1'b1), .load_val(4'd0),
    .up_strb(c_up), .dn_strb(c_dn),
    .count(lo_cnt), .up_tc_n(lo_utc), .dn_tc_n(lo_dtc));

  updown_strobe_counter #(.W(4), .DECADE(1'b1)) hi_i (
    .clk(clk), .clr(clr), .load_n(1'b1), .load_val(4'd0),
    .up_strb(lo_utc), .dn_strb(lo_dtc),
    .count(hi_cnt), .up_tc_n(hi_utc), .dn_tc_n(hi_dtc));

  function automatic int m_up(input int v, input int term);
    return (v >= term) ? 0 : v + 1;
  endfunction

  function automatic int m_dn(input int v, input int term);
    if (v == 0 || v > term) return term;
    return v - 1;
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_both(input string req);
    check(req, "decade count", int'(dec_cnt), exp_dec);
    check(req, "binary count", int'(bin_cnt), exp_bin);
  endtask

  task automatic do_clr();
    clr = 1'b1; tick(2); clr = 1'b0; tick(1);
    exp_dec = 0; exp_bin = 0; exp_c = 0;
  endtask

  task automatic do_load(input int v);
    load_val = 4'(v); load_n = 1'b0; tick(1); load_n = 1'b1;
    exp_dec = v; exp_bin = v;
  endtask

  task automatic pulse_up();
    up_s = 1'b0; tick(3); up_s = 1'b1; tick(4);
    exp_dec = m_up(exp_dec, 9); exp_bin = m_up(exp_bin, 15);
  endtask

  task automatic pulse_dn();
    dn_s = 1'b0; tick(3); dn_s = 1'b1; tick(4);
    exp_dec = m_dn(exp_dec, 9); exp_bin = m_dn(exp_bin, 15);
  endtask

  initial begin
    tick(150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    tick(3);
    clr = 1'b0;
    tick(1);

    // R5: reset state
    check_both("R5");
    check("R5", "decade up tc", int'(dec_utc), 1);
    check("R5", "decade down tc", int'(dec_dtc), 1);

    // R6: load
    do_load(5);
    check_both("R6");

    // R7: hold with idle strobes
    tick(12);
    check_both("R7");

    // R1 R2
    pulse_up();  check_both("R1");
    pulse_dn();  check_both("R2");
    pulse_dn();  check_both("R2");

    // R12: latency of a single step
    do_load(3);
    up_s = 1'b0; tick(3); up_s = 1'b1; tick(2);
    check("R12", "decade count before step", int'(dec_cnt), 3);
    tick(1);
    check("R12", "decade count at step", int'(dec_cnt), 4);
    tick(3);
    check("R12", "decade single step only", int'(dec_cnt), 4);
    exp_dec = 4; exp_bin = 4;

    // R3: wrap both ways
    do_load(9);  pulse_up(); check_both("R3");
    do_load(15); pulse_up(); check_both("R3");
    do_clr();    pulse_dn(); check_both("R3");

    // R4: out-of-range decade values
    do_load(12); pulse_up(); check_both("R4");
    do_load(13); pulse_dn(); check_both("R4");
    do_load(10); pulse_dn(); check_both("R4");

    // R10: up terminal count
    do_load(15);
    up_s = 1'b0; tick(3);
    check("R10", "binary up tc at 15 strobe low", int'(bin_utc), 0);
    check("R10", "decade up tc at 15 strobe low", int'(dec_utc), 1);
    up_s = 1'b1; tick(4);
    exp_dec = m_up(exp_dec, 9); exp_bin = m_up(exp_bin, 15);
    check("R10", "binary up tc after rise", int'(bin_utc), 1);
    check_both("R10");
    do_load(9);
    up_s = 1'b0; tick(3);
    check("R10", "decade up tc at 9 strobe low", int'(dec_utc), 0);
    check("R10", "binary up tc at 9 strobe low", int'(bin_utc), 1);
    up_s = 1'b1; tick(4);
    exp_dec = m_up(exp_dec, 9); exp_bin = m_up(exp_bin, 15);
    check_both("R10");

    // R11: down terminal count
    do_clr();
    dn_s = 1'b0; tick(3);
    check("R11", "decade down tc at 0 strobe low", int'(dec_dtc), 0);
    check("R11", "binary down tc at 0 strobe low", int'(bin_dtc), 0);
    dn_s = 1'b1; tick(4);
    exp_dec = m_dn(exp_dec, 9); exp_bin = m_dn(exp_bin, 15);
    check("R11", "decade down tc after rise", int'(dec_dtc), 1);
    check_both("R11");
    do_load(4);
    dn_s = 1'b0; tick(3);
    check("R11", "decade down tc at 4 strobe low", int'(dec_dtc), 1);
    dn_s = 1'b1; tick(4);
    exp_dec = m_dn(exp_dec, 9); exp_bin = m_dn(exp_bin, 15);
    check_both("R11");

    // R8: idle strobe low blocks the active strobe
    do_load(6);
    dn_s = 1'b0; tick(3);
    up_s = 1'b0; tick(3); up_s = 1'b1; tick(4);
    check_both("R8");
    dn_s = 1'b1; tick(4);
    exp_dec = m_dn(exp_dec, 9); exp_bin = m_dn(exp_bin, 15);
    check_both("R2");

    // R8: simultaneous rising edges
    up_s = 1'b0; dn_s = 1'b0; tick(3);
    up_s = 1'b1; dn_s = 1'b1; tick(5);
    check_both("R8");

    // R9: strobe held low through a load
    up_s = 1'b0; tick(3);
    do_load(6);
    tick(2);
    up_s = 1'b1; tick(4);
    exp_dec = m_up(exp_dec, 9); exp_bin = m_up(exp_bin, 15);
    check_both("R9");

    // R9 R5: strobe held low through clear, clear beating load
    up_s = 1'b0; tick(3);
    load_val = 4'd7; load_n = 1'b0; clr = 1'b1; tick(2);
    load_n = 1'b1; clr = 1'b0; tick(1);
    exp_dec = 0; exp_bin = 0;
    check_both("R5");
    tick(2);
    up_s = 1'b1; tick(4);
    exp_dec = m_up(exp_dec, 9); exp_bin = m_up(exp_bin, 15);
    check_both("R9");

    // R6: load taken while the down strobe is mid-pulse
    dn_s = 1'b0; tick(1);
    do_load(2);
    check_both("R6");
    dn_s = 1'b1; tick(4);
    exp_dec = m_dn(exp_dec, 9); exp_bin = m_dn(exp_bin, 15);
    check_both("R2");

    // Random mix: R1 R2 R3 R4 R6 R7
    for (int i = 0; i < 300; i++) begin
      int op;
      op = int'($urandom % 4);
      case (op)
        0: begin pulse_up(); check_both("R1"); end
        1: begin pulse_dn(); check_both("R2"); end
        2: begin do_load(int'($urandom % 16)); check_both("R6"); end
        default: begin tick(1 + int'($urandom % 6)); check_both("R7"); end
      endcase
    end

    // R13: two-stage chain
    do_clr();
    for (int i = 0; i < 120; i++) begin
      c_up = 1'b0; tick(3); c_up = 1'b1; tick(9);
      exp_c = (exp_c + 1) % 100;
      check("R13", "chain up value", int'(hi_cnt) * 10 + int'(lo_cnt), exp_c);
    end
    for (int i = 0; i < 130; i++) begin
      c_dn = 1'b0; tick(3); c_dn = 1'b1; tick(9);
      exp_c = (exp_c + 99) % 100;
      check("R13", "chain down value", int'(hi_cnt) * 10 + int'(lo_cnt), exp_c);
    end

    summary();
    $finish;
  end

endmodule